// File: doc/BRIEF.md
# Periodic Impedance Calibrator

This block is the digital half of an output-driver impedance tracking loop. An analogue comparator outside the block reports whether the driver is currently too weak or too strong against its sense resistor. The block holds the binary-weighted strength code that selects the driver legs, and it keeps that code following supply and temperature drift for as long as it runs.

A free-running interval counter opens one evaluation window every 1024 clock cycles and then starts counting again. At each evaluation the comparator result is sampled once. The code then moves by one least-significant step toward the match point, or it is held. Because only one step is allowed per evaluation, noise on the comparator cannot make the drivers jump. At either end of the code range the code stays where it is and a saturation flag is raised, so the code never wraps. A one-cycle strobe marks every change so that the driver slices can latch the new code.

Top module: `imp_calibrator`

## Requirements
- R1: While reset is asserted and right after it is released, `zcode` is mid-scale (2^(CODE_W-1), 32 for the default width), and `zcode_upd` and `zcode_sat` are low.
- R2: Evaluations happen on every 1024th rising clock edge counted from reset release (edges 1024, 2048, ...). `zcode` does not change on any other edge.
- R3: At an evaluation with `cmp_vld` high, `cmp_res` = 2'b01 (driver too weak) raises `zcode` by exactly one, and `cmp_res` = 2'b10 (driver too strong) lowers it by exactly one.
- R4: At an evaluation with `cmp_vld` high, `cmp_res` = 2'b00 or 2'b11 (matched) leaves `zcode` unchanged, gives no strobe and clears `zcode_sat`.
- R5: At an evaluation with `cmp_vld` low, `zcode` and `zcode_sat` keep their values and no strobe is given.
- R6: A raise request at all-ones or a lower request at all-zeros leaves the code unchanged and sets `zcode_sat`. The code never wraps. `zcode_sat` stays set until the next evaluation that has `cmp_vld` high and does not ask to go past a limit.
- R7: `zcode_upd` is high for exactly the one cycle that follows an edge on which `zcode` changed, and it is low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_vld | input | 1 | Comparator result is valid |
| cmp_res | input | 2 | Comparator result: 01 too weak, 10 too strong, 00/11 matched |
| zcode | output | CODE_W | Binary-weighted driver strength code |
| zcode_upd | output | 1 | One-cycle strobe when zcode changed |
| zcode_sat | output | 1 | Last valid evaluation asked to go past a code limit |

## Verification
The hardest states to reach are the two saturation corners. One step is allowed per 1024-cycle evaluation and the code starts at mid-scale, so reaching all-ones takes 31 evaluations and then reaching all-zeros takes 63 more. The stimulus holds the comparator input steady through long runs of evaluations until the code is pinned at each limit. It then requests one further step to raise the flag, and follows with an invalid evaluation and a matched evaluation to show that the flag holds and then clears. Reset is applied while the flag is set, to show that reset clears it.

// File: rtl/calib_pkg.sv
package calib_pkg;
  typedef enum logic [1:0] {
    VERDICT_MATCH  = 2'b00,
    VERDICT_WEAK   = 2'b01,
    VERDICT_STRONG = 2'b10,
    VERDICT_BOTH   = 2'b11
  } verdict_e;
endpackage

// File: rtl/calib_interval_timer.sv
module calib_interval_timer #(
  parameter int INTERVAL = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap = (cnt == LAST);
  assign tick = wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R2: the counter stays inside the interval range
  assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R2: after a tick the count restarts from zero
  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));
endmodule

// File: rtl/calib_code_stepper.sv
module calib_code_stepper
  import calib_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmp_vld,
  input  logic [1:0]        cmp_res,
  output logic [CODE_W-1:0] zcode,
  output logic              zcode_upd,
  output logic              zcode_sat
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] CODE_MIN = '0;
  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] ONE      = CODE_W'(1);

  // Returns {saturated, next code} for one evaluation.
  function automatic logic [CODE_W:0] step_code(
    input logic [CODE_W-1:0] cur,
    input logic              up,
    input logic              dn
  );
    logic [CODE_W-1:0] nxt;
    logic              sat;
    nxt = cur;
    sat = 1'b0;
    if (up) begin
      if (cur == CODE_MAX) sat = 1'b1;
      else                 nxt = cur + ONE;
    end else if (dn) begin
      if (cur == CODE_MIN) sat = 1'b1;
      else                 nxt = cur - ONE;
    end
    return {sat, nxt};
  endfunction

  verdict_e          verdict;
  logic              eval_now;
  logic              req_up;
  logic              req_dn;
  logic [CODE_W:0]   step_res;
  logic [CODE_W-1:0] code_nxt;
  logic              sat_nxt;
  logic              code_moves;

  assign verdict    = verdict_e'(cmp_res);
  assign eval_now   = tick && cmp_vld;
  assign req_up     = (verdict == VERDICT_WEAK);
  assign req_dn     = (verdict == VERDICT_STRONG);
  assign step_res   = step_code(zcode, req_up, req_dn);
  assign code_nxt   = step_res[CODE_W-1:0];
  assign sat_nxt    = step_res[CODE_W];
  assign code_moves = eval_now && (code_nxt != zcode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zcode     <= CODE_MID;
      zcode_upd <= 1'b0;
      zcode_sat <= 1'b0;
    end else begin
      zcode_upd <= code_moves;
      if (eval_now) begin
        zcode     <= code_nxt;
        zcode_sat <= sat_nxt;
      end
    end
  end

  // R2: the code changes only at an evaluation
  assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(zcode));

  // R3: the code moves by one step at most
  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (zcode == $past(zcode)) || (zcode == $past(zcode) + ONE)
             || (zcode == $past(zcode) - ONE));

  // R5: an invalid comparator result changes nothing
  assert_invalid_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cmp_vld) |=> ($stable(zcode) && $stable(zcode_sat)));

  // R6: no wrap at the top of the range
  assert_no_wrap_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (zcode == CODE_MAX) |=> (zcode != CODE_MIN));

  // R6: no wrap at the bottom of the range
  assert_no_wrap_bot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (zcode == CODE_MIN) |=> (zcode != CODE_MAX));

  // R7: the strobe follows each code change and nothing else
  assert_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (zcode_upd == (zcode != $past(zcode))));
endmodule

// File: rtl/imp_calibrator.sv
module imp_calibrator #(
  parameter int CODE_W   = 6,
  parameter int INTERVAL = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_vld,
  input  logic [1:0]        cmp_res,
  output logic [CODE_W-1:0] zcode,
  output logic              zcode_upd,
  output logic              zcode_sat
);
  logic eval_tick;

  calib_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (eval_tick)
  );

  calib_code_stepper #(.CODE_W(CODE_W)) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (eval_tick),
    .cmp_vld   (cmp_vld),
    .cmp_res   (cmp_res),
    .zcode     (zcode),
    .zcode_upd (zcode_upd),
    .zcode_sat (zcode_sat)
  );

  // R7: the strobe never lasts two cycles
  assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zcode_upd |=> !zcode_upd);
endmodule

// File: tb/sim_imp_calibrator.sv
module sim_imp_calibrator;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_vld = 1'b0;
  logic [1:0] cmp_res = 2'b00;
  logic [5:0] zcode;
  logic       zcode_upd;
  logic       zcode_sat;

  int checks = 0;
  int errors = 0;
  int edges_done = 0;
  int ref_code = 32;
  int ref_sat = 0;
  bit finished = 1'b0;

  // vector: {valid, cmp[1:0], code[5:0], strobe, sat}
  localparam logic [10:0] VEC [0:7] = '{
    {1'b1, 2'b01, 6'd33, 1'b1, 1'b0},
    {1'b1, 2'b01, 6'd34, 1'b1, 1'b0},
    {1'b1, 2'b10, 6'd33, 1'b1, 1'b0},
    {1'b1, 2'b00, 6'd33, 1'b0, 1'b0},
    {1'b1, 2'b11, 6'd33, 1'b0, 1'b0},
    {1'b0, 2'b01, 6'd33, 1'b0, 1'b0},
    {1'b0, 2'b10, 6'd33, 1'b0, 1'b0},
    {1'b1, 2'b10, 6'd32, 1'b1, 1'b0}
  };

  imp_calibrator u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_vld   (cmp_vld),
    .cmp_res   (cmp_res),
    .zcode     (zcode),
    .zcode_upd (zcode_upd),
    .zcode_sat (zcode_sat)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  int obs_code, obs_upd, obs_sat, pre_code, pre_upd, nxt_upd, exp_upd;

  // Drive inputs at a falling edge, run to the next evaluation edge, observe.
  task automatic run_eval(input logic v, input logic [1:0] c);
    cmp_vld = v;
    cmp_res = c;
    repeat (1023 - edges_done) @(posedge clk);
    #1;
    pre_code = zcode; pre_upd = zcode_upd;
    @(posedge clk); #1;
    obs_code = zcode; obs_upd = zcode_upd; obs_sat = zcode_sat;
    @(posedge clk); #1;
    nxt_upd = zcode_upd;
    edges_done = 1;
    @(negedge clk);
    exp_upd = 0;
    if (v) begin
      if (c == 2'b01) begin
        if (ref_code == 63) ref_sat = 1;
        else begin ref_code++; ref_sat = 0; exp_upd = 1; end
      end else if (c == 2'b10) begin
        if (ref_code == 0) ref_sat = 1;
        else begin ref_code--; ref_sat = 0; exp_upd = 1; end
      end else ref_sat = 0;
    end
  endtask

  task automatic check_eval(input string tag);
    check({tag, " code"}, obs_code, ref_code);
    check({tag, " sat"}, obs_sat, ref_sat);
    check("R7 strobe at change", obs_upd, exp_upd);
    check("R7 strobe drops", nxt_upd, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset code", zcode, 32);
    check("R1 reset strobe", zcode_upd, 0);
    check("R1 reset sat", zcode_sat, 0);
    @(negedge clk);
    rst_n = 1'b1;
    edges_done = 0;
    ref_code = 32;
    ref_sat = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R2 watchdog actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R2: first evaluation lands on edge 1024, not 1023
    run_eval(1'b1, 2'b01);
    check("R2 no change before edge 1024", pre_code, 32);
    check("R2 no strobe before edge 1024", pre_upd, 0);
    check("R2 change at edge 1024", obs_code, 33);
    ref_code = 32;
    cmp_vld = 1'b1; cmp_res = 2'b10;
    // bring code back to mid-scale and keep model aligned
    ref_code = 33;
    run_eval(1'b1, 2'b10);
    check_eval("R3 lower");

    // table walk: R3, R4, R5
    for (int i = 0; i < 8; i++) begin
      run_eval(VEC[i][10], VEC[i][9:8]);
      check("R3 R4 R5 table code", obs_code, int'(VEC[i][7:2]));
      check("R7 table strobe", obs_upd, int'(VEC[i][1]));
      check("R4 R6 table sat", obs_sat, int'(VEC[i][0]));
      check_eval("R3 R4 R5 model");
    end

    // R6: climb to all-ones, then one more raise
    for (int i = 0; i < 31; i++) begin
      run_eval(1'b1, 2'b01);
      check_eval("R3 climb");
    end
    check("R6 at top", obs_code, 63);
    run_eval(1'b1, 2'b01);
    check_eval("R6 top clamp");
    check("R6 top sat set", obs_sat, 1);
    run_eval(1'b0, 2'b00);
    check_eval("R5 sat held");
    check("R6 sat held by invalid", obs_sat, 1);
    run_eval(1'b1, 2'b00);
    check_eval("R4 sat cleared");
    check("R4 matched clears sat", obs_sat, 0);

    // R6: descend to all-zeros, then one more lower
    for (int i = 0; i < 63; i++) begin
      run_eval(1'b1, 2'b10);
      check_eval("R3 descend");
    end
    check("R6 at bottom", obs_code, 0);
    run_eval(1'b1, 2'b10);
    check_eval("R6 bottom clamp");
    check("R6 bottom sat set", obs_sat, 1);

    // R1: reset while saturated, then restart
    @(negedge clk);
    do_reset();
    run_eval(1'b1, 2'b01);
    check_eval("R2 R3 after reset");
    check("R3 first raise after reset", obs_code, 33);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule